// File: doc/BRIEF.md
# Programmable Watchdog Countdown Timer

This block is a supervisory watchdog. It holds an 8-bit down-counter that moves on one of four selectable tick enables: a 4.096 kHz tick, a 64 Hz tick, a 1 Hz tick, or a 1/60 Hz tick. The 1/60 Hz tick is made inside the block by dividing the 1 Hz tick by 60. All ticks are one-cycle enable pulses in the single system clock domain.

Host software sets up the block through a small register interface with three registers:

- a control register that holds a two-bit mode field and a two-bit tick-select field;
- a value register that loads the counter and reads back the live count;
- a status register that shows a sticky expiry flag.

When the count expires, the flag is set. Depending on the mode, the flag then drives a level interrupt output or a level reset output. The counter never reloads by itself. Software keeps the system alive by writing the value register again before expiry. Writing zero to the value register parks the timer.

Top module: `wdt_countdown`

## Requirements
- R1: After synchronous reset the count is 0, the flag is 0, the control register reads 0, and both `irq_o` and `wdrst_o` are low.
- R2: The mode field is control bits [7:6]. Values 00 and 01 are disabled: the count holds on every tick, the flag never sets, and both outputs stay low.
- R3: The tick-select field is control bits [1:0]. 00 selects `tick_4k_i`, 01 selects `tick_64_i`, 10 selects `tick_1hz_i`, and 11 selects the internal slow tick. Pulses on unselected ticks do not move the count.
- R4: In mode 10 or 11, while the flag is 0 and the count is not 0, each selected tick lowers the count by exactly one. A count of 0 never moves and never wraps.
- R5: The flag sets on the selected tick that arrives while the count is 1. The count then stays at 1 and the flag stays set, whatever further ticks arrive, so the timeout is n ticks after loading n.
- R6: `irq_o` is high exactly when the flag is set and the mode is 10. `wdrst_o` is high exactly when the flag is set and the mode is 11. Both follow a later change of mode as levels.
- R7: Writing a nonzero n to the value register (address 1) clears the flag, drops both outputs, and restarts the countdown from n.
- R8: Writing 0 to the value register clears the flag, drops both outputs, and leaves the timer stopped at 0.
- R9: The internal slow tick fires on every 60th `tick_1hz_i` pulse counted from reset. Its phase is not disturbed by register writes.
- R10: Changing the tick-select field during a countdown keeps the current count. The new tick applies from its next pulse.
- R11: The read port is combinational. Address 0 returns the control register with bits [5:2] reading 0. Address 1 returns the live count. Address 2 returns the flag in bit 0 with the other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_4k_i | input | 1 | 4.096 kHz tick enable pulse |
| tick_64_i | input | 1 | 64 Hz tick enable pulse |
| tick_1hz_i | input | 1 | 1 Hz tick enable pulse; also feeds the divide-by-60 stage |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address: 0 control, 1 value |
| wr_data_i | input | CNT_W | Write data |
| rd_addr_i | input | 2 | Read address: 0 control, 1 count, 2 status |
| rd_data_o | output | CNT_W | Read data |
| irq_o | output | 1 | Level interrupt on expiry in mode 10 |
| wdrst_o | output | 1 | Level reset request on expiry in mode 11 |

## Verification
The bench aims at several corner cases:

- **Loading n = 1.** The flag must rise on the very next selected tick. A design that expires one tick early flags at load time; one that runs to 0 wraps or flags a tick late.
- **Ticks after expiry and ticks at count 0.** The count must stay at 1 after expiry and stay at 0 when parked. A reloading or underflowing counter would show up in the read-back count.
- **The slow tick.** It is run across 120 one-second pulses. A divider with an off-by-one count moves the expiry point.
- **Tick select and mode changes in mid-count.** These must not reset the count, and the outputs must track the mode at once.
- **Random operation sequences.** They mix writes, unselected ticks and disabled modes against a bench model. This catches a count that moves on the wrong tick, or a flag that clears without a value write.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    // Operating mode held in the upper two bits of the control register.
    typedef enum logic [1:0] {
        WM_OFF_A = 2'b00,
        WM_OFF_B = 2'b01,
        WM_IRQ   = 2'b10,
        WM_RESET = 2'b11
    } wd_mode_e;

    // Decrement tick choice held in the lower two bits of the control register.
    typedef enum logic [1:0] {
        TS_4K   = 2'b00,
        TS_64   = 2'b01,
        TS_1HZ  = 2'b10,
        TS_SLOW = 2'b11
    } tick_sel_e;

    // Register map of the host port.
    typedef enum logic [1:0] {
        RA_CTRL   = 2'd0,
        RA_VALUE  = 2'd1,
        RA_STATUS = 2'd2,
        RA_RSVD   = 2'd3
    } reg_addr_e;

    typedef struct packed {
        wd_mode_e  mode;
        tick_sel_e tsel;
    } wd_ctrl_t;

    // Load request to the countdown core.
    typedef struct packed {
        logic valid;
        logic [7:0] value;
    } wd_load_t;

    localparam wd_ctrl_t CTRL_RESET = '{mode: WM_OFF_A, tsel: TS_4K};

    // Only the two upper mode codes let the counter run.
    function automatic logic mode_armed(input wd_mode_e m);
        return (m == WM_IRQ) || (m == WM_RESET);
    endfunction

    // Pick one of the four tick enables.
    function automatic logic tick_pick(input tick_sel_e s,
                                       input logic t4k,
                                       input logic t64,
                                       input logic t1,
                                       input logic tslow);
        logic r;
        unique case (s)
            TS_4K:   r = t4k;
            TS_64:   r = t64;
            TS_1HZ:  r = t1;
            default: r = tslow;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen
    import wdt_pkg::*;
#(
    parameter int unsigned DIV_SLOW = 60
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick_4k_i,
    input  logic      tick_64_i,
    input  logic      tick_1hz_i,
    input  tick_sel_e tsel_i,
    output logic      tick_o,
    output logic      slow_tick_o
);
    localparam int unsigned PW = (DIV_SLOW > 2) ? $clog2(DIV_SLOW) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(DIV_SLOW - 1);

    logic [PW-1:0] pre_q;
    logic          pre_wrap;

    // The slow tick coincides with the 1 Hz pulse that completes a full cycle.
    assign pre_wrap = tick_1hz_i && (pre_q == PRE_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= '0;
        end else if (tick_1hz_i) begin
            pre_q <= pre_wrap ? '0 : pre_q + 1'b1;
        end
    end

    assign slow_tick_o = pre_wrap;
    assign tick_o      = tick_pick(tsel_i, tick_4k_i, tick_64_i, tick_1hz_i, pre_wrap);

endmodule

// File: rtl/wdt_core.sv
module wdt_core
    import wdt_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             armed_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic [CNT_W-1:0] count_o,
    output logic             flag_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic             flag_q;
    logic             live;
    logic             step;

    // The counter runs only while loaded, not yet expired, and armed.
    assign live = (cnt_q != '0) && !flag_q;
    assign step = tick_i && armed_i && live;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            flag_q <= 1'b0;
        end else if (load_i) begin
            cnt_q  <= load_val_i;
            flag_q <= 1'b0;
        end else if (step) begin
            if (cnt_q == ONE) begin
                flag_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q - ONE;
            end
        end
    end

    assign count_o = cnt_q;
    assign flag_o  = flag_q;

endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_addr_i,
    input  logic [CNT_W-1:0] wr_data_i,
    input  logic [1:0]       rd_addr_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             flag_i,
    output wd_ctrl_t         ctrl_o,
    output logic             load_o,
    output logic [CNT_W-1:0] load_val_o,
    output logic [CNT_W-1:0] rd_data_o
);
    localparam int unsigned MID_W = CNT_W - 4;

    wd_ctrl_t  ctrl_q;
    reg_addr_e wsel;
    reg_addr_e rsel;

    assign wsel = reg_addr_e'(wr_addr_i);
    assign rsel = reg_addr_e'(rd_addr_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RESET;
        end else if (wr_en_i && (wsel == RA_CTRL)) begin
            ctrl_q.mode <= wd_mode_e'(wr_data_i[CNT_W-1 -: 2]);
            ctrl_q.tsel <= tick_sel_e'(wr_data_i[1:0]);
        end
    end

    assign load_o     = wr_en_i && (wsel == RA_VALUE);
    assign load_val_o = wr_data_i;
    assign ctrl_o     = ctrl_q;

    always_comb begin
        unique case (rsel)
            RA_CTRL:   rd_data_o = {ctrl_q.mode, {MID_W{1'b0}}, ctrl_q.tsel};
            RA_VALUE:  rd_data_o = count_i;
            RA_STATUS: rd_data_o = {{(CNT_W-1){1'b0}}, flag_i};
            default:   rd_data_o = '0;
        endcase
    end

endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown
    import wdt_pkg::*;
#(
    parameter int unsigned CNT_W    = 8,
    parameter int unsigned DIV_SLOW = 60
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_4k_i,
    input  logic             tick_64_i,
    input  logic             tick_1hz_i,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_addr_i,
    input  logic [CNT_W-1:0] wr_data_i,
    input  logic [1:0]       rd_addr_i,
    output logic [CNT_W-1:0] rd_data_o,
    output logic             irq_o,
    output logic             wdrst_o
);
    wd_ctrl_t         ctrl_q;
    logic             load;
    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] cur_count;
    logic             wd_flag;
    logic             sel_tick;
    logic             slow_tick;
    logic [1:0]       mode_bits;

    wdt_regs #(.CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en_i    (wr_en_i),
        .wr_addr_i  (wr_addr_i),
        .wr_data_i  (wr_data_i),
        .rd_addr_i  (rd_addr_i),
        .count_i    (cur_count),
        .flag_i     (wd_flag),
        .ctrl_o     (ctrl_q),
        .load_o     (load),
        .load_val_o (load_val),
        .rd_data_o  (rd_data_o)
    );

    wdt_tick_gen #(.DIV_SLOW(DIV_SLOW)) u_ticks (
        .clk         (clk),
        .rst         (rst),
        .tick_4k_i   (tick_4k_i),
        .tick_64_i   (tick_64_i),
        .tick_1hz_i  (tick_1hz_i),
        .tsel_i      (ctrl_q.tsel),
        .tick_o      (sel_tick),
        .slow_tick_o (slow_tick)
    );

    wdt_core #(.CNT_W(CNT_W)) u_core (
        .clk        (clk),
        .rst        (rst),
        .tick_i     (sel_tick),
        .armed_i    (mode_armed(ctrl_q.mode)),
        .load_i     (load),
        .load_val_i (load_val),
        .count_o    (cur_count),
        .flag_o     (wd_flag)
    );

    assign mode_bits = ctrl_q.mode;
    assign irq_o     = wd_flag && (ctrl_q.mode == WM_IRQ);
    assign wdrst_o   = wd_flag && (ctrl_q.mode == WM_RESET);

endmodule

// File: rtl/wdt_countdown_chk.sv
module wdt_countdown_chk #(
    parameter int unsigned CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [1:0]       wr_addr,
    input logic [CNT_W-1:0] wr_data,
    input logic [CNT_W-1:0] count,
    input logic             flag,
    input logic [1:0]       mode,
    input logic             irq,
    input logic             wdrst,
    input logic             slow_tick
);
    logic load;
    assign load = wr_en && (wr_addr == 2'd1);

    // R2: disabled modes keep both outputs low
    a_r2_quiet_off: assert property (@(posedge clk) disable iff (rst)
        !mode[1] |-> (!irq && !wdrst));

    // R2: disabled modes freeze the count
    a_r2_hold_off: assert property (@(posedge clk) disable iff (rst)
        (!mode[1] && !load) |=> $stable(count));

    // R4: without a load the count only holds or drops by one
    a_r4_step_one: assert property (@(posedge clk) disable iff (rst)
        (!load && count != '0) |=> (count == $past(count) || count == CNT_W'($past(count) - 1'b1)));

    // R4: a parked count never wraps
    a_r4_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (!load && count == '0) |=> (count == '0));

    // R5: expiry leaves the count at one
    a_r5_expire_at_one: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> (count == CNT_W'(1)));

    // R5: the flag is sticky until a value write
    a_r5_sticky: assert property (@(posedge clk) disable iff (rst)
        (flag && !load) |=> flag);

    // R6: the two outputs are never high together
    a_r6_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(irq && wdrst));

    // R7 and R8: a value write clears the flag and loads the count
    a_r7_reload: assert property (@(posedge clk) disable iff (rst)
        load |=> (!flag && !irq && !wdrst && count == $past(wr_data)));

    // R9: the slow tick is a single-cycle pulse
    a_r9_slow_pulse: assert property (@(posedge clk) disable iff (rst)
        slow_tick |=> !slow_tick);
endmodule

bind wdt_countdown wdt_countdown_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en_i),
    .wr_addr   (wr_addr_i),
    .wr_data   (wr_data_i),
    .count     (cur_count),
    .flag      (wd_flag),
    .mode      (mode_bits),
    .irq       (irq_o),
    .wdrst     (wdrst_o),
    .slow_tick (slow_tick)
);

// File: tb/wdt_countdown_bench.sv
module wdt_countdown_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic t4k = 1'b0, t64 = 1'b0, t1 = 1'b0;
    logic wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0, rd_addr = 2'd0;
    logic [CNT_W-1:0] wr_data = '0;
    logic [CNT_W-1:0] rd_data;
    logic irq, wdrst;

    int tests = 0;
    int fails = 0;

    // bench model, built from the requirements
    logic [7:0] m_cnt;
    logic       m_flag;
    logic [1:0] m_mode, m_tsel;
    int         m_pre;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdt_countdown u_wdt_countdown (
        .clk(clk), .rst(rst),
        .tick_4k_i(t4k), .tick_64_i(t64), .tick_1hz_i(t1),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .irq_o(irq), .wdrst_o(wdrst)
    );

    function automatic logic [7:0] exp_ctrl();
        return {m_mode, 4'b0000, m_tsel};
    endfunction

    function automatic logic exp_irq();
        return m_flag && (m_mode == 2'b10);
    endfunction

    function automatic logic exp_rst();
        return m_flag && (m_mode == 2'b11);
    endfunction

    task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_state(input string req);
        rd_addr = 2'd1; #1;
        check(req, "count", rd_data, m_cnt);
        rd_addr = 2'd2; #1;
        check(req, "status", rd_data, {7'b0, m_flag});
        rd_addr = 2'd0; #1;
        check(req, "control", rd_data, exp_ctrl());
        check(req, "irq", {7'b0, irq}, {7'b0, exp_irq()});
        check(req, "wdrst", {7'b0, wdrst}, {7'b0, exp_rst()});
    endtask

    task automatic do_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (a == 2'd0) begin
            m_mode = d[7:6];
            m_tsel = d[1:0];
        end else if (a == 2'd1) begin
            m_cnt  = d;
            m_flag = 1'b0;
        end
    endtask

    // which: 0 = 4 kHz, 1 = 64 Hz, 2 = 1 Hz
    task automatic pulse(input int which);
        logic fire;
        logic slow;
        @(negedge clk);
        t4k = (which == 0); t64 = (which == 1); t1 = (which == 2);
        @(negedge clk);
        t4k = 1'b0; t64 = 1'b0; t1 = 1'b0;
        slow = 1'b0;
        if (which == 2) begin
            slow  = (m_pre == 59);
            m_pre = slow ? 0 : m_pre + 1;
        end
        fire = (m_tsel == 2'(which) && which < 3) || (m_tsel == 2'b11 && slow);
        if (fire && m_mode[1] && m_cnt != 0 && !m_flag) begin
            if (m_cnt == 8'd1) m_flag = 1'b1;
            else m_cnt = m_cnt - 8'd1;
        end
    endtask

    task automatic pulses(input int which, input int k);
        for (int i = 0; i < k; i++) pulse(which);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        m_cnt = 0; m_flag = 0; m_mode = 0; m_tsel = 0; m_pre = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_state("R1");

        // R2: disabled mode holds count
        do_write(2'd0, 8'b01_0000_00);
        do_write(2'd1, 8'd3);
        pulses(0, 5);
        check_state("R2");
        check("R2", "count held", m_cnt, 8'd3);

        // R3: only the selected tick moves the count
        do_write(2'd0, 8'b10_0000_01);
        do_write(2'd1, 8'd10);
        pulses(0, 3); pulses(2, 3);
        check_state("R3");
        pulses(1, 2);
        check_state("R3");
        check("R3", "count after 64Hz", m_cnt, 8'd8);

        // R5: n = 1 expires on the first tick, no reload
        do_write(2'd0, 8'b10_0000_00);
        do_write(2'd1, 8'd1);
        check_state("R5");
        pulse(0);
        check_state("R5");
        check("R5", "irq after n=1", {7'b0, irq}, 8'd1);
        pulses(0, 4);
        check_state("R5");

        // R6: outputs follow the mode as levels
        do_write(2'd0, 8'b11_0000_00);
        check_state("R6");
        check("R6", "reset level", {7'b0, wdrst}, 8'd1);
        do_write(2'd0, 8'b00_0000_00);
        check_state("R6");

        // R7: nonzero write re-arms
        do_write(2'd0, 8'b11_0000_00);
        do_write(2'd1, 8'd4);
        check_state("R7");
        pulses(0, 3);
        check_state("R7");
        pulse(0);
        check_state("R7");
        check("R7", "reset after 4", {7'b0, wdrst}, 8'd1);

        // R8: zero write stops; R4: parked count never wraps
        do_write(2'd1, 8'd0);
        pulses(0, 5);
        check_state("R8");
        check("R4", "parked count", m_cnt, 8'd0);

        // R10: change tick select mid-count
        do_write(2'd0, 8'b10_0000_00);
        do_write(2'd1, 8'd6);
        pulses(0, 2);
        do_write(2'd0, 8'b10_0000_01);
        check_state("R10");
        check("R10", "count kept", m_cnt, 8'd4);
        pulses(0, 2); pulses(1, 1);
        check_state("R10");

        // R9: slow tick, one decrement per 60 one-second pulses
        do_write(2'd0, 8'b10_0000_11);
        do_write(2'd1, 8'd2);
        pulses(2, 60 - m_pre);
        check_state("R9");
        pulses(2, 59);
        check_state("R9");
        pulse(2);
        check_state("R9");
        check("R9", "slow expiry", {7'b0, irq}, 8'd1);

        // R11: reserved control bits read zero
        do_write(2'd0, 8'b11_1111_10);
        check_state("R11");

        // random mix: R4 and R3 against the model
        for (int it = 0; it < 400; it++) begin
            int op;
            op = $urandom_range(0, 9);
            if (op == 0) do_write(2'd0, 8'($urandom));
            else if (op == 1) do_write(2'd1, 8'($urandom_range(0, 6)));
            else if (op == 2) do_write(2'd1, 8'($urandom));
            else pulses($urandom_range(0, 2), $urandom_range(1, 4));
            check_state("R4");
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule